// File: doc/BRIEF.md
# Watchdog Timer with Tap-Selected Prescaler

This block watches for a stalled program. It counts ticks from one of two sources: a free-running slow oscillator or the instruction clock, which is the system clock divided by four. The ticks reach the block as single-cycle clock-enable strobes in the system clock domain. A fixed 8-bit stage divides the ticks by 256. A 7-bit prescaler follows it, and a 3-bit tap code selects a further power-of-two division. When the selected count completes, the block raises a one-cycle time-out pulse.

Software keeps the watchdog quiet by asserting the clear input more often than once per period. A configuration-level enable switches the whole block off. When the instruction clock is the source, a halted core stops the count. The slow oscillator keeps counting through halt.

Top module: `wdt_tap_timer`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, `timeout_o` is 0, and both counters start from zero.
- R2: `src_sel_i` = 0 counts `slow_tick_i` strobes and `src_sel_i` = 1 counts `instr_tick_i` strobes. Strobes on the unselected input have no effect on the count.
- R3: With tap code 0 the time-out fires once every 256 counted ticks.
- R4: Tap code n (0..7) gives a period of 256 × 2^n counted ticks, so code 3 gives 2048 and code 7 gives 32768.
- R5: With `src_sel_i` = 1 and `halt_i` = 1, instruction ticks are not counted, and the count resumes from where it stopped once halt is released.
- R6: With `src_sel_i` = 0, `halt_i` has no effect on counting.
- R7: The time-out is a one-cycle pulse. It goes high in the cycle after the edge that registers the terminal tick. After that the counters wrap, and the pulse repeats every period until the counters are cleared.
- R8: `clear_i` = 1 returns both counters to zero, and the next time-out then needs a full period of ticks.
- R9: If `clear_i` is asserted in the same cycle as the terminal tick, the clear wins and no pulse is produced.
- R10: With `wdt_en_i` = 0, no time-out is produced and the counters are held at zero, so `clear_i` and the ticks have no effect. After the block is re-enabled, a full period is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick_i | input | 1 | Tick strobe from the slow oscillator |
| instr_tick_i | input | 1 | Tick strobe from the instruction clock |
| src_sel_i | input | 1 | Count source: 0 = slow oscillator, 1 = instruction clock |
| tap_sel_i | input | 3 | Tap code n, giving a prescaler division of 2^n |
| clear_i | input | 1 | Restarts the count from zero |
| halt_i | input | 1 | The core is halted |
| wdt_en_i | input | 1 | Configuration enable; 0 turns the watchdog off |
| timeout_o | output | 1 | One-cycle time-out pulse |

## Verification
The clear and the terminal tick can land in the same cycle. In that case the clear must suppress the pulse that the tick would otherwise produce. The bench provokes this by counting to one tick short of the period, then driving a tick and a clear together. It expects the output to stay low in that cycle and to rise only after a further full 256 ticks. Halt is also asserted together with a steady stream of instruction ticks, and the pulse must move back by exactly the number of cycles spent halted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BASE_W = 8;
  localparam int PRE_W  = 7;
  localparam int SEL_W  = $clog2(PRE_W + 1);
endpackage

// File: rtl/wdt_src_gate.sv
module wdt_src_gate (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick_i,
  input  logic instr_tick_i,
  input  logic src_sel_i,
  input  logic halt_i,
  input  logic en_i,
  output logic tick_o
);
  logic picked;

  always_comb begin
    if (src_sel_i) picked = instr_tick_i & ~halt_i;
    else           picked = slow_tick_i;
    tick_o = picked & en_i;
  end

  // R5: in halt with the instruction clock selected, no tick leaves the gate
  p_halt_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i && halt_i) |-> !tick_o);
endmodule

// File: rtl/wdt_base_div.sv
module wdt_base_div #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  output logic carry_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt <= '0;
    else if (tick_i)  cnt <= cnt + 1'b1;
  end

  assign carry_o = tick_i & ~clr_i & (&cnt);

  // R8: a clear leaves the base stage at zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt == '0));
  // R5: without a tick the base stage holds its value
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt));
endmodule

// File: rtl/wdt_tap_prescaler.sv
module wdt_tap_prescaler #(
  parameter int W  = 7,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [SW-1:0] sel_i,
  output logic          hit_o
);
  logic [W-1:0] cnt;
  logic [W:0]   tap_ok;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt <= '0;
    else if (step_i)  cnt <= cnt + 1'b1;
  end

  assign tap_ok[0] = 1'b1;
  for (genvar g = 1; g <= W; g++) begin : g_tap
    assign tap_ok[g] = &cnt[g-1:0];
  end

  assign hit_o = step_i & tap_ok[sel_i];

  // R7: the prescaler wraps to zero after its last value
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (step_i && (&cnt)) |=> (cnt == '0));
endmodule

// File: rtl/wdt_tap_timer.sv
module wdt_tap_timer
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_tick_i,
  input  logic             instr_tick_i,
  input  logic             src_sel_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  input  logic             clear_i,
  input  logic             halt_i,
  input  logic             wdt_en_i,
  output logic             timeout_o
);
  logic tick, base_carry, tap_hit, stage_clr;

  assign stage_clr = clear_i | ~wdt_en_i;

  wdt_src_gate u_gate (
    .clk(clk), .rst(rst),
    .slow_tick_i(slow_tick_i), .instr_tick_i(instr_tick_i),
    .src_sel_i(src_sel_i), .halt_i(halt_i), .en_i(wdt_en_i),
    .tick_o(tick)
  );

  wdt_base_div #(.W(BASE_W)) u_base (
    .clk(clk), .rst(rst), .clr_i(stage_clr),
    .tick_i(tick), .carry_o(base_carry)
  );

  wdt_tap_prescaler #(.W(PRE_W), .SW(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .clr_i(stage_clr),
    .step_i(base_carry), .sel_i(tap_sel_i), .hit_o(tap_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) timeout_o <= 1'b0;
    else     timeout_o <= tap_hit & ~stage_clr;
  end

  // R7: the pulse never lasts more than one cycle
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);
  // R10: a disabled watchdog stays silent
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !wdt_en_i |=> !timeout_o);
  // R9: a clear suppresses the pulse in the following cycle
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !timeout_o);
  // R5: a halted core with the instruction source cannot time out
  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i && halt_i) |=> !timeout_o);
  // R1: one cycle after reset the output is still low
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !timeout_o);
endmodule

// File: tb/wdt_tap_timer_tb.sv
`timescale 1ns/1ps
module wdt_tap_timer_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic slow_tick = 0, instr_tick = 0, src_sel = 0, clear = 0, halt = 0, en = 1;
  logic [2:0] tap_sel = 0;
  logic timeout;

  int checks = 0, errors = 0, cycles = 0;
  int mcount = 0;
  logic       cur_src = 0;
  logic [2:0] cur_sel = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  wdt_tap_timer u_dut (
    .clk(clk), .rst(rst), .slow_tick_i(slow_tick), .instr_tick_i(instr_tick),
    .src_sel_i(src_sel), .tap_sel_i(tap_sel), .clear_i(clear),
    .halt_i(halt), .wdt_en_i(en), .timeout_o(timeout)
  );

  // driver: one cycle of stimulus plus the expected output after the next edge
  task automatic cyc(input logic s, input logic i, input logic h,
                     input logic c, input logic e, input string tag);
    item_t it;
    logic eff;
    int period;
    @(negedge clk);
    slow_tick = s; instr_tick = i; halt = h; clear = c; en = e;
    src_sel = cur_src; tap_sel = cur_sel;
    period = 256 << cur_sel;
    eff = e && (cur_src ? (i && !h) : s);
    it.tag = tag;
    it.exp = 1'b0;
    if (!e || c) mcount = 0;
    else if (eff) begin
      it.exp = (((mcount + 1) % period) == 0);
      mcount = (mcount + 1) % 32768;
    end
    q.push_back(it);
  endtask

  // monitor: compares just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (timeout !== it.exp) begin
        errors++;
        $display("FAIL %s: timeout_o=%0b expected %0b", it.tag, timeout, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (timeout !== 1'b0) begin
      errors++;
      $display("FAIL R1: timeout_o=%0b expected 0 in reset", timeout);
    end
    rst = 1'b0;
    cyc(0, 0, 0, 0, 1, "R1");
    // R3 and R7: tap 0, two periods back to back
    for (int k = 0; k < 512; k++) cyc(1, 0, 0, 0, 1, "R3_R7");
    // R8: partial count, clear, full period again
    cyc(0, 0, 0, 1, 1, "R8");
    for (int k = 0; k < 200; k++) cyc(1, 0, 0, 0, 1, "R8");
    cyc(0, 0, 0, 1, 1, "R8");
    for (int k = 0; k < 256; k++) cyc(1, 0, 0, 0, 1, "R8");
    // R9: clear together with the terminal tick
    cyc(0, 0, 0, 1, 1, "R9");
    for (int k = 0; k < 255; k++) cyc(1, 0, 0, 0, 1, "R9");
    cyc(1, 0, 0, 1, 1, "R9");
    for (int k = 0; k < 256; k++) cyc(1, 0, 0, 0, 1, "R9");
    // R2: instruction source, slow strobes are ignored
    cur_src = 1;
    cyc(0, 0, 0, 1, 1, "R2");
    for (int k = 0; k < 100; k++) cyc(1, 0, 0, 0, 1, "R2");
    for (int k = 0; k < 256; k++) cyc(0, 1, 0, 0, 1, "R2");
    // R5: halt freezes the instruction-clock count
    cyc(0, 0, 0, 1, 1, "R5");
    for (int k = 0; k < 100; k++) cyc(0, 1, 0, 0, 1, "R5");
    for (int k = 0; k < 300; k++) cyc(1, 1, 1, 0, 1, "R5");
    for (int k = 0; k < 156; k++) cyc(0, 1, 0, 0, 1, "R5");
    // R6: halt does not affect the slow source; instr strobes ignored (R2)
    cur_src = 0;
    cyc(0, 0, 0, 1, 1, "R6");
    for (int k = 0; k < 100; k++) cyc(1, 1, 0, 0, 1, "R6");
    for (int k = 0; k < 156; k++) cyc(1, 0, 1, 0, 1, "R6");
    // R10: disabled, ticks and clear do nothing, then full period
    for (int k = 0; k < 300; k++) cyc(1, 0, 0, (k == 150), 0, "R10");
    for (int k = 0; k < 256; k++) cyc(1, 0, 0, 0, 1, "R10");
    // R4: sparse ticks with tap 1, then taps 3 and 7
    cur_sel = 1;
    cyc(0, 0, 0, 1, 1, "R4");
    for (int k = 0; k < 1024; k++) cyc(k[0], 0, 0, 0, 1, "R4");
    cur_sel = 3;
    cyc(0, 0, 0, 1, 1, "R4");
    for (int k = 0; k < 2048; k++) cyc(1, 0, 0, 0, 1, "R4");
    cur_sel = 7;
    cyc(0, 0, 0, 1, 1, "R4");
    for (int k = 0; k < 32768 + 10; k++) cyc(1, 0, 0, 0, 1, "R4_R7");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule